// File: doc/BRIEF.md
# Multi-Mode Page Table Walker

This block turns a virtual address into a physical address by reading a tree of translation tables held in memory. A request carries the virtual address, a two-bit layout select and the base of the top-level table. The walker then reads one table entry per level over a single-outstanding read port. Each entry it reads must be marked present, and its upper bits give the base of the next table. The entry at the lowest level gives the 4 KB frame base. The walker ends by reporting either the physical address or a fault.

Three table layouts share the same datapath. The first is a 32-bit layout with two levels and 4-byte entries. The second is a widened layout with three levels, 8-byte entries, a four-entry top table and 36-bit physical addresses. The third is a 48-bit layout with four levels, 8-byte entries and 52-bit physical addresses. In the 48-bit layout the address must first pass a sign-extension check before any read is made. Only one walk runs at a time. Each result is marked by a one-cycle `done` pulse and carries the number of reads the walk made.

Top module: `pgw_top`

## Requirements
- R1: Layout 0 (two levels): req_vaddr[31:22] indexes the top table and req_vaddr[21:12] indexes the second. Entries are 4 bytes and are taken from mem_rsp_data[31:0]. Table addresses and the result are truncated to 32 bits.
- R2: Layout 1 (three levels): req_vaddr[31:30], [29:21] and [20:12] index levels 3, 2 and 1. Entries are 8 bytes. Addresses and the result are truncated to 36 bits, so entry bits above 35 are ignored.
- R3: Layout 2 (four levels): req_vaddr[47:39], [38:30], [29:21] and [20:12] index levels 4 down to 1. Entries are 8 bytes. Addresses and the result are truncated to 52 bits.
- R4: In layout 2, if req_vaddr[63:48] is not all copies of req_vaddr[47], the walk ends with fault type 2, zero reads, level 0, and no memory request. In layouts 0 and 1, req_vaddr[63:32] is ignored.
- R5: The address of each entry read is the table base plus the index times the entry size, masked to the layout's physical width. The first base is root_base with bits 11:0 cleared. Every later base is the previous entry's bits above 11, with bits 11:0 cleared.
- R6: Bit 0 of an entry is the present flag. If it is clear, the walk stops with res_fault=1, fault type 1, res_paddr=0, res_level equal to the level read (the top level is the level count, the lowest is 1), and res_reads counting that read.
- R7: A walk that succeeds reports res_fault=0, type 0, level 0, res_reads equal to the level count (2, 3 or 4), and res_paddr equal to the last entry's frame bits joined with req_vaddr[11:0].
- R8: Layout select 3 ends at once with fault type 3, zero reads and no memory request.
- R9: req_ready is high only while no walk is active. mem_req_valid holds with a stable mem_req_addr until mem_req_ready. Grant stalls and response latency may be any length.
- R10: done is a one-cycle pulse. It is high in the cycle after the clock edge that takes the last read response, or after the edge that accepts a request which faults without a read.
- R11: During reset, req_ready=1, mem_req_valid=0 and done=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_mode | input | 2 | Layout select: 0 two-level, 1 three-level, 2 four-level, 3 reserved |
| req_vaddr | input | VA_W | Virtual address |
| root_base | input | PA_W | Base of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DATA_W | Entry data |
| done | output | 1 | Result pulse |
| res_paddr | output | PA_W | Physical address, zero on fault |
| res_fault | output | 1 | Walk ended in a fault |
| res_ftype | output | 2 | 0 none, 1 not present, 2 non-canonical, 3 reserved layout |
| res_level | output | 3 | Level of a not-present fault, else 0 |
| res_reads | output | CNT_W | Number of entry reads performed |

## Verification
Results that need no memory read are due one cycle after the edge that accepts the request. Every other result is due one cycle after the edge that takes the final read response. The bench counts cycles and records the cycle in which it returns the last response its reference walk expects. It then requires `done` in exactly that cycle and at no other time. The bench checks each entry address when it grants the read, so a wrong index, entry size or truncation shows up at the level where it occurs. The tests are run twice: once with no grant stall and no response delay, and once with long stalls and delays.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

   typedef enum logic [1:0] {
      MD_TWO   = 2'd0,
      MD_THREE = 2'd1,
      MD_FOUR  = 2'd2,
      MD_RSVD  = 2'd3
   } walk_mode_e;

   typedef enum logic [1:0] {
      FT_NONE     = 2'd0,
      FT_ABSENT   = 2'd1,
      FT_NONCANON = 2'd2,
      FT_BADMODE  = 2'd3
   } fault_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } walk_state_e;

   function automatic logic [2:0] levels_of(walk_mode_e m);
      case (m)
         MD_TWO:   return 3'd2;
         MD_THREE: return 3'd3;
         MD_FOUR:  return 3'd4;
         default:  return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/pgw_canon.sv
module pgw_canon #(
   parameter int VA_W    = 64,
   parameter int TOP_BIT = 47
) (
   input  logic [VA_W-1:0] va,
   output logic            ok
);
   localparam int HI_W = VA_W - TOP_BIT;

   if (HI_W > 1) begin : g_check
      logic [HI_W-1:0] hi;
      assign hi = va[VA_W-1:TOP_BIT];
      assign ok = (&hi) | ~(|hi);
      logic unused_lo;
      assign unused_lo = ^va[TOP_BIT-1:0];
   end else begin : g_none
      assign ok = 1'b1;
      logic unused_va;
      assign unused_va = ^va;
   end
endmodule

// File: rtl/pgw_index.sv
module pgw_index
   import pgw_pkg::*;
#(
   parameter int SPAN_W = 48,
   parameter int IDX_W  = 10,
   parameter int NSLICE = 4,
   parameter int SL_W   = 9
) (
   input  logic [SPAN_W-1:0] va,
   input  walk_mode_e        mode,
   input  logic [2:0]        level,
   output logic [IDX_W-1:0]  idx
);
   logic [SL_W-1:0] slice [NSLICE];

   for (genvar l = 0; l < NSLICE; l++) begin : g_slice
      assign slice[l] = va[12 + SL_W*l +: SL_W];
   end

   always_comb begin
      idx = '0;
      case (mode)
         MD_TWO: begin
            if (level == 3'd2) idx = IDX_W'(va[31:22]);
            else               idx = IDX_W'(va[21:12]);
         end
         MD_THREE: begin
            case (level)
               3'd3:    idx = IDX_W'(va[31:30]);
               3'd2:    idx = IDX_W'(va[29:21]);
               default: idx = IDX_W'(va[20:12]);
            endcase
         end
         MD_FOUR: begin
            case (level)
               3'd4:    idx = IDX_W'(slice[3]);
               3'd3:    idx = IDX_W'(slice[2]);
               3'd2:    idx = IDX_W'(slice[1]);
               default: idx = IDX_W'(slice[0]);
            endcase
         end
         default: idx = '0;
      endcase
   end
endmodule

// File: rtl/pgw_entry.sv
module pgw_entry
   import pgw_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int PA_W     = 52,
   parameter int PA_TWO   = 32,
   parameter int PA_THREE = 36,
   parameter int PA_FOUR  = 52
) (
   input  logic [DATA_W-1:0] data,
   input  walk_mode_e        mode,
   output logic              present,
   output logic [PA_W-1:0]   frame,
   output logic [PA_W-1:0]   pa_mask
);
   localparam int OFF_W = 12;

   logic [PA_W-1:0]   m_two, m_three, m_four, low_clr;
   logic [DATA_W-1:0] raw;

   for (genvar b = 0; b < PA_W; b++) begin : g_mask
      assign m_two[b]   = (b < PA_TWO);
      assign m_three[b] = (b < PA_THREE);
      assign m_four[b]  = (b < PA_FOUR);
      assign low_clr[b] = (b >= OFF_W);
   end

   assign raw = (mode == MD_TWO) ? {{(DATA_W-32){1'b0}}, data[31:0]} : data;

   always_comb begin
      case (mode)
         MD_TWO:   pa_mask = m_two;
         MD_THREE: pa_mask = m_three;
         default:  pa_mask = m_four;
      endcase
   end

   assign present = raw[0];
   assign frame   = raw[PA_W-1:0] & pa_mask & low_clr;

   if (DATA_W > PA_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^raw[DATA_W-1:PA_W];
   end
endmodule

// File: rtl/pgw_top.sv
module pgw_top
   import pgw_pkg::*;
#(
   parameter int VA_W     = 64,
   parameter int PA_W     = 52,
   parameter int DATA_W   = 64,
   parameter int PA_TWO   = 32,
   parameter int PA_THREE = 36,
   parameter int PA_FOUR  = 52,
   parameter int CNT_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_mode,
   input  logic [VA_W-1:0]   req_vaddr,
   input  logic [PA_W-1:0]   root_base,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [PA_W-1:0]   mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rsp_data,
   output logic              done,
   output logic [PA_W-1:0]   res_paddr,
   output logic              res_fault,
   output logic [1:0]        res_ftype,
   output logic [2:0]        res_level,
   output logic [CNT_W-1:0]  res_reads
);
   localparam int SPAN_W = 48;
   localparam int IDX_W  = 10;
   localparam int OFF_W  = 12;

   if (VA_W < SPAN_W) begin : g_bad_va
      $error("pgw_top: VA_W must cover a 48-bit span");
   end
   if (PA_TWO > PA_THREE || PA_THREE > PA_FOUR || PA_FOUR > PA_W) begin : g_bad_pa
      $error("pgw_top: physical widths must grow per layout and fit PA_W");
   end
   if (PA_TWO <= OFF_W) begin : g_bad_two
      $error("pgw_top: physical width must exceed page offset");
   end
   if (DATA_W < 64 || DATA_W < PA_W) begin : g_bad_data
      $error("pgw_top: read data must hold an 8-byte entry");
   end
   if ((1 << CNT_W) <= 4) begin : g_bad_cnt
      $error("pgw_top: read counter too narrow for four levels");
   end

   walk_state_e       st;
   walk_mode_e        mode_q;
   logic [SPAN_W-1:0] va_q;
   logic [PA_W-1:0]   base_q;
   logic [2:0]        lvl_q;
   logic [CNT_W-1:0]  reads_q;

   logic              done_q;
   logic [PA_W-1:0]   r_paddr;
   logic              r_fault;
   fault_e            r_ftype;
   logic [2:0]        r_level;
   logic [CNT_W-1:0]  r_reads;

   logic              canon_ok;
   logic [IDX_W-1:0]  idx;
   logic              ent_present;
   logic [PA_W-1:0]   ent_frame;
   logic [PA_W-1:0]   pa_mask;
   logic [PA_W-1:0]   ent_off;
   walk_mode_e        in_mode;

   logic unused_root;
   assign unused_root = ^root_base[OFF_W-1:0];

   assign in_mode = walk_mode_e'(req_mode);

   pgw_canon #(.VA_W(VA_W), .TOP_BIT(SPAN_W-1)) u_canon (
      .va (req_vaddr),
      .ok (canon_ok)
   );

   pgw_index #(.SPAN_W(SPAN_W), .IDX_W(IDX_W)) u_index (
      .va    (va_q),
      .mode  (mode_q),
      .level (lvl_q),
      .idx   (idx)
   );

   pgw_entry #(
      .DATA_W  (DATA_W),
      .PA_W    (PA_W),
      .PA_TWO  (PA_TWO),
      .PA_THREE(PA_THREE),
      .PA_FOUR (PA_FOUR)
   ) u_entry (
      .data    (mem_rsp_data),
      .mode    (mode_q),
      .present (ent_present),
      .frame   (ent_frame),
      .pa_mask (pa_mask)
   );

   assign ent_off      = (mode_q == MD_TWO) ? (PA_W'(idx) << 2) : (PA_W'(idx) << 3);
   assign mem_req_addr = (base_q + ent_off) & pa_mask;

   assign req_ready     = (st == ST_IDLE);
   assign mem_req_valid = (st == ST_ISSUE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         mode_q  <= MD_TWO;
         va_q    <= '0;
         base_q  <= '0;
         lvl_q   <= '0;
         reads_q <= '0;
         done_q  <= 1'b0;
         r_paddr <= '0;
         r_fault <= 1'b0;
         r_ftype <= FT_NONE;
         r_level <= '0;
         r_reads <= '0;
      end else begin
         done_q <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  mode_q  <= in_mode;
                  va_q    <= req_vaddr[SPAN_W-1:0];
                  base_q  <= {root_base[PA_W-1:OFF_W], {OFF_W{1'b0}}};
                  lvl_q   <= levels_of(in_mode);
                  reads_q <= '0;
                  if (in_mode == MD_RSVD) begin
                     done_q  <= 1'b1;
                     r_paddr <= '0;
                     r_fault <= 1'b1;
                     r_ftype <= FT_BADMODE;
                     r_level <= '0;
                     r_reads <= '0;
                  end else if (in_mode == MD_FOUR && !canon_ok) begin
                     done_q  <= 1'b1;
                     r_paddr <= '0;
                     r_fault <= 1'b1;
                     r_ftype <= FT_NONCANON;
                     r_level <= '0;
                     r_reads <= '0;
                  end else begin
                     st <= ST_ISSUE;
                  end
               end
            end
            ST_ISSUE: begin
               if (mem_req_ready) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rsp_valid) begin
                  reads_q <= reads_q + 1'b1;
                  if (!ent_present) begin
                     st      <= ST_IDLE;
                     done_q  <= 1'b1;
                     r_paddr <= '0;
                     r_fault <= 1'b1;
                     r_ftype <= FT_ABSENT;
                     r_level <= lvl_q;
                     r_reads <= reads_q + 1'b1;
                  end else if (lvl_q == 3'd1) begin
                     st      <= ST_IDLE;
                     done_q  <= 1'b1;
                     r_paddr <= ent_frame | PA_W'(va_q[OFF_W-1:0]);
                     r_fault <= 1'b0;
                     r_ftype <= FT_NONE;
                     r_level <= '0;
                     r_reads <= reads_q + 1'b1;
                  end else begin
                     base_q <= ent_frame;
                     lvl_q  <= lvl_q - 3'd1;
                     st     <= ST_ISSUE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign done      = done_q;
   assign res_paddr = r_paddr;
   assign res_fault = r_fault;
   assign res_ftype = r_ftype;
   assign res_level = r_level;
   assign res_reads = r_reads;

endmodule

// File: rtl/pgw_chk.sv
module pgw_chk
   import pgw_pkg::*;
#(
   parameter int PA_W  = 52,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic             req_ready,
   input logic [1:0]       req_mode,
   input logic [11:0]      req_lo,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [PA_W-1:0]  mem_req_addr,
   input logic             done,
   input logic [PA_W-1:0]  res_paddr,
   input logic             res_fault,
   input logic [1:0]       res_ftype,
   input logic [2:0]       res_level,
   input logic [CNT_W-1:0] res_reads
);
   walk_mode_e mode_c;
   logic [11:0] lo_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_c <= MD_TWO;
         lo_c   <= '0;
      end else if (req_valid && req_ready) begin
         mode_c <= walk_mode_e'(req_mode);
         lo_c   <= req_lo;
      end
   end

   AST_ONE_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_ready && mem_req_valid));                                        // R9
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                       // R10
   AST_NONCANON_NOREAD: assert property (@(posedge clk) disable iff (!rst_n)
      done && res_ftype == FT_NONCANON |-> res_reads == '0 && res_level == 3'd0); // R4
   AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      done && res_fault |-> res_paddr == '0);                                // R6
   AST_OK_READS: assert property (@(posedge clk) disable iff (!rst_n)
      done && !res_fault |-> res_reads == CNT_W'(levels_of(mode_c)));        // R7
   AST_OK_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      done && !res_fault |-> res_paddr[11:0] == lo_c);                       // R7
   AST_BADMODE: assert property (@(posedge clk) disable iff (!rst_n)
      done && mode_c == MD_RSVD |-> res_ftype == FT_BADMODE && res_reads == '0); // R8
endmodule

bind pgw_top pgw_chk #(.PA_W(PA_W), .CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_mode      (req_mode),
   .req_lo        (req_vaddr[11:0]),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .done          (done),
   .res_paddr     (res_paddr),
   .res_fault     (res_fault),
   .res_ftype     (res_ftype),
   .res_level     (res_level),
   .res_reads     (res_reads)
);

// File: tb/tb_pgw_top.sv
module tb_pgw_top;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_mode = 2'd0;
   logic [63:0] req_vaddr = '0;
   logic [51:0] root_base = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [51:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        done;
   logic [51:0] res_paddr;
   logic        res_fault;
   logic [1:0]  res_ftype;
   logic [2:0]  res_level;
   logic [2:0]  res_reads;

   pgw_top dut (.*);

   always #4 clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   int cyc = 0;
   int due = -1;
   int ndone = 0;
   int stall = 0;
   int lat = 0;
   bit fin = 1'b0;
   string cur_tag = "R11";

   logic [63:0] mem [logic [63:0]];
   logic [63:0] addr_q [$];
   logic [63:0] pool = 64'h0010_0000;

   logic [63:0] exp_paddr;
   logic        exp_fault;
   logic [1:0]  exp_ftype;
   logic [2:0]  exp_level;
   logic [2:0]  exp_reads;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] pw_mask(input int md);
      if (md == 0) return 64'h0000_0000_FFFF_FFFF;
      if (md == 1) return 64'h0000_000F_FFFF_FFFF;
      return 64'h000F_FFFF_FFFF_FFFF;
   endfunction

   function automatic logic [63:0] ent_addr(input int md, input logic [63:0] base,
                                            input logic [63:0] va, input int l);
      int iw = (md == 0) ? 10 : 9;
      int esz = (md == 0) ? 4 : 8;
      logic [63:0] ve = (md == 2) ? va : (va & 64'hFFFF_FFFF);
      logic [63:0] ix = (ve >> (12 + iw*(l-1))) & ((64'd1 << iw) - 1);
      return (base + ix*esz) & pw_mask(md);
   endfunction

   function automatic logic [63:0] rd(input logic [63:0] a);
      if (mem.exists(a)) return mem[a];
      return 64'd0;
   endfunction

   task automatic build(input int md, input logic [63:0] root, input logic [63:0] va,
                        input logic [63:0] frame, input int fail_lvl);
      logic [63:0] base = root & pw_mask(md) & ~64'hFFF;
      logic [63:0] junk = (md == 0) ? 64'hDEAD_BEEF_0000_0000 :
                          (md == 1) ? 64'hABCD_E000_0000_0000 : 64'hFFF0_0000_0000_0000;
      for (int l = md + 2; l >= 1; l--) begin
         logic [63:0] a = ent_addr(md, base, va, l);
         logic [63:0] nxt = pool;
         if (l == fail_lvl) begin
            mem[a] = junk | pool | 64'h0E6;
            break;
         end else if (l == 1) begin
            mem[a] = junk | frame | 64'h0E7;
         end else begin
            mem[a] = junk | nxt | 64'h0E7;
            pool += 64'h1000;
            base = nxt;
         end
      end
   endtask

   task automatic model(input int md, input logic [63:0] va, input logic [63:0] root);
      logic [63:0] base;
      exp_paddr = 0; exp_fault = 0; exp_ftype = 0; exp_level = 0; exp_reads = 0;
      addr_q.delete();
      if (md == 3) begin
         exp_fault = 1; exp_ftype = 3;
         return;
      end
      if (md == 2 && va[63:48] != {16{va[47]}}) begin
         exp_fault = 1; exp_ftype = 2;
         return;
      end
      base = root & pw_mask(md) & ~64'hFFF;
      for (int l = md + 2; l >= 1; l--) begin
         logic [63:0] a = ent_addr(md, base, va, l);
         logic [63:0] e = rd(a);
         addr_q.push_back(a);
         exp_reads++;
         if (md == 0) e = e & 64'hFFFF_FFFF;
         if (!e[0]) begin
            exp_fault = 1; exp_ftype = 1; exp_level = 3'(l);
            return;
         end
         base = e & pw_mask(md) & ~64'hFFF;
      end
      exp_paddr = base | (va & 64'hFFF);
   endtask

   task automatic run(input int md, input logic [63:0] va, input logic [63:0] root,
                      input string tag);
      int n0 = ndone;
      model(md, va, root);
      cur_tag = tag;
      @(negedge clk);
      req_mode = 2'(md);
      req_vaddr = va;
      root_base = 52'(root);
      req_valid = 1'b1;
      if (addr_q.size() == 0) due = cyc + 1;
      @(negedge clk);
      req_valid = 1'b0;
      while (ndone == n0 && !fin) @(negedge clk);
      chk({tag, " reads left"}, 64'(addr_q.size()), 64'd0);
      repeat (2) @(negedge clk);
   endtask

   initial forever begin
      @(posedge clk);
      cyc++;
   end

   // memory model with programmable grant stall and response latency
   initial forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
         logic [63:0] a;
         repeat (stall) @(negedge clk);
         a = 64'(mem_req_addr);
         if (addr_q.size() == 0) begin
            nchk++; nerr++;
            $display("FAIL R4 R8 unexpected read actual %0h expected none", a);
         end else begin
            chk("R5 R9 entry address", a, addr_q.pop_front());
         end
         mem_req_ready = 1'b1;
         @(negedge clk);
         mem_req_ready = 1'b0;
         repeat (lat) @(negedge clk);
         mem_rsp_data = rd(a);
         mem_rsp_valid = 1'b1;
         if (addr_q.size() == 0) due = cyc + 1;
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         mem_rsp_data = '0;
      end
   end

   // result monitor, compared every cycle
   initial forever begin
      @(negedge clk);
      #1;
      if (rst_n && (done || cyc == due)) begin
         chk({cur_tag, " R10 done timing"}, 64'(done), 64'(cyc == due));
         if (done) begin
            chk({cur_tag, " paddr"}, 64'(res_paddr), exp_paddr);
            chk({cur_tag, " fault"}, 64'(res_fault), 64'(exp_fault));
            chk({cur_tag, " ftype"}, 64'(res_ftype), 64'(exp_ftype));
            chk({cur_tag, " level"}, 64'(res_level), 64'(exp_level));
            chk({cur_tag, " reads"}, 64'(res_reads), 64'(exp_reads));
            ndone++;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!fin) begin
         fin = 1'b1;
         nchk++; nerr++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset req_ready", 64'(req_ready), 64'd1);
      chk("R11 reset mem_req_valid", 64'(mem_req_valid), 64'd0);
      chk("R11 reset done", 64'(done), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int pass = 0; pass < 2; pass++) begin
         stall = (pass == 0) ? 0 : 3;
         lat   = (pass == 0) ? 0 : 5;

         build(0, 64'h0000_5123, 64'h1234_5678, 64'h7654_3000, 0);
         run(0, 64'h1234_5678, 64'h0000_5123, "R1 R7");
         run(0, 64'hFFFF_0000_1234_5678, 64'h0000_5123, "R1 R4 high bits ignored");

         build(1, 64'h0000_6000, 64'hC031_2ABC, 64'h9_ABCD_E000, 0);
         run(1, 64'hC031_2ABC, 64'h0000_6000, "R2 R7");

         build(2, 64'h0000_7000, 64'hFFFF_8123_4567_89AB, 64'hF_EDCB_A987_6000, 0);
         run(2, 64'hFFFF_8123_4567_89AB, 64'h0000_7000, "R3 R7 upper half");
         build(2, 64'h0000_8000, 64'h0000_7FFF_FFFF_F123, 64'h1_0000_0000_0000, 0);
         run(2, 64'h0000_7FFF_FFFF_F123, 64'h0000_8000, "R3 R7 top of lower half");

         run(2, 64'h0001_0000_0000_0000, 64'h0000_7000, "R4 noncanonical");
         run(2, 64'hFFFF_0000_0000_0000, 64'h0000_7000, "R4 sign mismatch");
         run(3, 64'h0000_0000_1234_5678, 64'h0000_5000, "R8 reserved layout");

         build(0, 64'h0000_9000, 64'h0040_1000, 64'h1000, 2);
         run(0, 64'h0040_1000, 64'h0000_9000, "R6 absent top level");
         build(2, 64'h0000_A000, 64'h0000_1234_5678_9000, 64'h2000, 3);
         run(2, 64'h0000_1234_5678_9000, 64'h0000_A000, "R6 absent level 3");
         build(1, 64'h0000_B000, 64'h8765_4321, 64'h3000, 1);
         run(1, 64'h8765_4321, 64'h0000_B000, "R6 absent lowest level");
      end

      fin = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule